// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block is the digital front end of a 7-bit binary-weighted step attenuator. It produces a registered 7-bit attenuation code in which bit 6 is the 16 dB step and bit 0 the 0.25 dB step. The code is all ones for 31.75 dB and all zeros for the insertion-loss reference state. A mode input selects the interface that programs the code.

In serial mode, a serial clock, a data line and a latch enable load a 16-bit word. The code is applied only when the address carried in that word equals the three static address pins. In parallel mode, seven control lines drive the code. When latch enable is held low the lines are captured on a latch pulse, and when latch enable is held high the code follows the lines.

All strobes are brought into the system clock domain through two-stage synchronisers, and the block acts on edges detected there. After reset the code is the maximum. In direct parallel mode the block holds the maximum for a programmable number of cycles before it adopts the parallel inputs.

Top module: `step_atten_ctrl`

## Requirements
- R1: `mode_ser_i` low selects the parallel interface and high selects the serial interface. In serial mode the parallel lines have no effect on `atten_o`, even with `latch_i` held high.
- R2: In serial mode, `sdata_i` is shifted in on each rising edge of `sclk_i`, least significant bit first. The 8-bit attenuation word comes first and the 8-bit address word follows. After 16 clocks, attenuation-word bits 6..0 form the code.
- R3: A rising edge of `latch_i` in serial mode applies the code only when bits 2..0 of the address word equal `addr_i`. The upper five address bits are ignored. On a mismatch, `atten_o` keeps its previous value.
- R4: Serial clock edges that arrive while `latch_i` is high do not shift, so they have no effect on the word that the next latch pulse applies.
- R5: While a serial word is being shifted in with `latch_i` low, `atten_o` does not change.
- R6: In latched parallel mode, with `latch_i` low, changes on `par_code_i` are not applied. A rising edge of `latch_i` captures `par_code_i`.
- R7: In direct parallel mode, with `latch_i` held high, `atten_o` follows `par_code_i`.
- R8: Reset drives `atten_o` to 7'h7F. In serial and latched parallel modes it stays there until a word is latched.
- R9: In direct parallel mode, `atten_o` stays at 7'h7F for `PUP_CYCLES` cycles after reset and then adopts `par_code_i`.
- R10: Attenuation-word bit 7 is latched with the word but never appears on `atten_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_ser_i | input | 1 | Interface select, 1 = serial |
| latch_i | input | 1 | Latch enable shared by both interfaces |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data |
| addr_i | input | 3 | Static device address |
| par_code_i | input | 7 | Parallel attenuation code |
| atten_o | output | 7 | Registered attenuation code |

## Verification
The bench programs address 3 with the 18.25 dB word (0x49) and checks that the output does not move while the bits are shifting. A design that shifted in the wrong bit order, or applied the code before the latch pulse, would show a different value. It then sends a word to another address, where an implementation that skips the address compare would overwrite the code. It also sends a word with bit 7 set, and clocks in junk data while the latch is high, which a shifter with no latch gating would absorb. On the parallel side, the bench checks the power-up hold in direct mode at the halfway point and after the delay has expired. It also checks that latched mode holds until the pulse arrives, and that the parallel lines are ignored in serial mode. Resetting a second time in serial mode shows whether a design wrongly releases the maximum code once the delay has expired.

// File: rtl/step_atten_pkg.sv
package step_atten_pkg;
  localparam int CODE_W  = 7;
  localparam int WORD_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int SHIFT_W = 2 * WORD_W;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
endpackage

// File: rtl/sa_sync.sv
module sa_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/sa_shift.sv
module sa_shift
  import step_atten_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_en_i,
  input  logic               latch_lvl_i,
  input  logic               sdata_i,
  output logic [SHIFT_W-1:0] shreg_o
);
  logic [SHIFT_W-1:0] shreg_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shreg_q <= '0;
    else if (shift_en_i) shreg_q <= {sdata_i, shreg_q[SHIFT_W-1:1]};
  end
  assign shreg_o = shreg_q;

  AST_NO_SHIFT_LATCH_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_lvl_i |=> $stable(shreg_q)); // R4
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import step_atten_pkg::*;
#(
  parameter int PUP_CYCLES = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_ser_i,
  input  logic              latch_lvl_i,
  input  logic              latch_rise_i,
  input  logic [CODE_W-1:0] ser_code_i,
  input  logic              ser_match_i,
  input  logic [CODE_W-1:0] par_code_i,
  output logic [CODE_W-1:0] atten_o
);
  localparam int CNT_W = $clog2(PUP_CYCLES + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PUP_CYCLES);

  logic [CNT_W-1:0]  pup_cnt_q;
  logic              pup_done;
  logic [CODE_W-1:0] atten_q;
  logic              ser_load, par_load, par_follow;

  assign pup_done = (pup_cnt_q == CNT_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pup_cnt_q <= '0;
    else if (!pup_done) pup_cnt_q <= pup_cnt_q + 1'b1;
  end

  assign ser_load   = mode_ser_i && latch_rise_i && ser_match_i;
  assign par_load   = !mode_ser_i && latch_rise_i;
  assign par_follow = !mode_ser_i && latch_lvl_i && pup_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     atten_q <= CODE_MAX;
    else if (ser_load)               atten_q <= ser_code_i;
    else if (par_load || par_follow) atten_q <= par_code_i;
  end
  assign atten_o = atten_q;

  AST_PUP_STAYS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pup_done |=> pup_done); // R9
  AST_SER_MISMATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ser_i && !ser_match_i) |=> $stable(atten_q)); // R3
  AST_SER_NO_PAR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ser_i && !latch_rise_i) |=> $stable(atten_q)); // R1
  AST_LATCHED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_ser_i && !latch_lvl_i) |=> $stable(atten_q)); // R6
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import step_atten_pkg::*;
#(
  parameter int PUP_CYCLES = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_ser_i,
  input  logic              latch_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] par_code_i,
  output logic [CODE_W-1:0] atten_o
);
  // sync order: {mode, latch, sclk, sdata}; latch resets high so no false edge
  logic [3:0]         sync_q;
  logic               s_mode, s_latch, s_sclk, s_sdata;
  logic               latch_d_q, sclk_d_q;
  logic               latch_rise, sclk_rise;
  logic [SHIFT_W-1:0] shreg;
  logic               addr_match;

  sa_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mode_ser_i, latch_i, sclk_i, sdata_i}),
    .q_o   (sync_q)
  );
  assign {s_mode, s_latch, s_sclk, s_sdata} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_d_q <= 1'b1;
      sclk_d_q  <= 1'b0;
    end else begin
      latch_d_q <= s_latch;
      sclk_d_q  <= s_sclk;
    end
  end
  assign latch_rise = s_latch && !latch_d_q;
  assign sclk_rise  = s_sclk && !sclk_d_q;

  sa_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (s_mode && sclk_rise && !s_latch),
    .latch_lvl_i(s_latch),
    .sdata_i    (s_sdata),
    .shreg_o    (shreg)
  );

  assign addr_match = (shreg[WORD_W +: ADDR_W] == addr_i);

  sa_ctrl #(.PUP_CYCLES(PUP_CYCLES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_ser_i  (s_mode),
    .latch_lvl_i (s_latch),
    .latch_rise_i(latch_rise),
    .ser_code_i  (shreg[CODE_W-1:0]),
    .ser_match_i (addr_match),
    .par_code_i  (par_code_i),
    .atten_o     (atten_o)
  );

  AST_SHIFT_HOLDS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_mode && !s_latch) |=> $stable(atten_o)); // R5
endmodule

// File: tb/step_atten_ctrl_bench.sv
module step_atten_ctrl_bench;
  localparam int PUP = 200;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_ser = 1'b0, latch = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [2:0] addr = 3'd3;
  logic [6:0] par = 7'h15;
  logic [6:0] atten;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {logic [6:0] v; string tag;} exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  step_atten_ctrl #(.PUP_CYCLES(PUP)) u_step_atten_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .mode_ser_i(mode_ser), .latch_i(latch),
    .sclk_i(sclk), .sdata_i(sdata), .addr_i(addr), .par_code_i(par), .atten_o(atten)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (atten !== e.v) begin
        n_fail++;
        $display("FAIL %s: atten_o=%h expected=%h", e.tag, atten, e.v);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(logic [6:0] v, string tag);
    cyc(8);
    exp_q.push_back('{v, tag});
    cyc(1);
  endtask

  task automatic shift_word(logic [7:0] adw, logic [7:0] atw, logic le_lvl);
    logic [15:0] w;
    w = {adw, atw};
    latch = le_lvl;
    for (int i = 0; i < 16; i++) begin
      sdata = w[i];
      cyc(4);
      sclk = 1'b1;
      cyc(4);
      sclk = 1'b0;
    end
    cyc(4);
  endtask

  task automatic pulse_latch();
    latch = 1'b1;
    cyc(6);
    latch = 1'b0;
    cyc(6);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    exp_q.push_back('{7'h7F, "R8 reset max"});
    cyc(PUP / 2);
    exp_q.push_back('{7'h7F, "R9 direct power-up hold"});
    cyc(PUP);
    expect_val(7'h15, "R9 direct adopt preset");
    par = 7'h2A;
    expect_val(7'h2A, "R7 direct follow");
    par = 7'h00;
    expect_val(7'h00, "R7 direct follow zero");
    latch = 1'b0;
    cyc(6);
    par = 7'h01;
    expect_val(7'h00, "R6 latched hold");
    pulse_latch();
    expect_val(7'h01, "R6 latched capture");
    // serial mode, address 3, 18.25 dB = 0x49
    mode_ser = 1'b1;
    cyc(6);
    shift_word(8'hF3, 8'h49, 1'b0);
    exp_q.push_back('{7'h01, "R5 no change while shifting"});
    cyc(1);
    pulse_latch();
    expect_val(7'h49, "R2 serial word applied");
    shift_word(8'h05, 8'h11, 1'b0);
    pulse_latch();
    expect_val(7'h49, "R3 address mismatch holds");
    shift_word(8'h03, 8'h85, 1'b0);
    pulse_latch();
    expect_val(7'h05, "R10 bit7 dropped");
    shift_word(8'h03, 8'h22, 1'b0);
    shift_word(8'h03, 8'h7E, 1'b1);
    latch = 1'b0;
    cyc(6);
    pulse_latch();
    expect_val(7'h22, "R4 clocks with latch high ignored");
    latch = 1'b1;
    par = 7'h3C;
    expect_val(7'h22, "R1 parallel ignored in serial");
    // second reset in serial mode
    rst_ni = 1'b0;
    latch = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(PUP + 20);
    expect_val(7'h7F, "R8 serial stays max after reset");
    cyc(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule